// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block is the power-management state machine of a small processor system. The processor asks for one of three low-power modes: sleep, stop or standby. For stop mode, one extra bit picks whether the regulator stays in its main setting or drops to its low-power setting. The block then drives the processor clock gate, the core-domain clock gate, the PLL and oscillator enables, a two-bit regulator setting, and the core-domain isolation and reset. Each mode gates a different set of resources.

While the system is in a low-power mode, the block watches only the wakeup sources that belong to that mode. When one of them fires, it sequences the return to run. Leaving stop restores the regulator, then the internal oscillator, then the core clocks. Leaving standby holds the core domain in reset for a fixed number of cycles and sets a sticky standby flag that the core reset does not clear. The regulator-ready and oscillator-ready handshakes are plain inputs.

Top module: `lpm_seq`

## Requirements
- R1: After reset, the processor and core clocks are enabled, the internal oscillator is enabled, the PLL is off, reg_mode is main (2'b01), core_iso and core_rst are low, and sbf is low.
- R2: rtc_clk_en and wdg_clk_en are high in every mode and every transition state.
- R3: A request is accepted only in run. req_mode selects the mode: 2'b01 is sleep, 2'b10 is stop, 2'b11 is standby, and 2'b00 is ignored. After acceptance, an entry sequence of ENTRY_CYC cycles runs with all outputs as in run, and then the mode's gating applies.
- R4: Sleep gates only cpu_clk_en. The core clock, the oscillators, the PLL and the regulator stay as in run. Only irq_pending wakes from sleep, and the system is back in run one cycle after it.
- R5: Stop lowers cpu_clk_en, core_clk_en, pll_en, hsi_en and hse_en. reg_mode is low-power (2'b10) when req_lp was high at acceptance, and main (2'b01) otherwise.
- R6: Stop wakes on any bit of ext_line, on vdet, on rtc_alarm or on usb_wake. irq_pending and wkup_pin have no effect in stop.
- R7: Leaving stop follows a fixed order. First reg_mode is main while hsi_en stays low, until reg_ready is high. Then hsi_en is high while the core clocks stay gated, until osc_ready is high. Then both clocks return.
- R8: After stop or standby, pll_en stays low in run until a pll_on pulse. In run and sleep, pll_en follows that permission.
- R9: Standby drives reg_mode to off (2'b00), lowers the PLL, the oscillator and both clock enables, and raises core_iso and core_rst.
- R10: Standby exits on ext_rst_evt, on wdog_rst, on rtc_alarm, or on a rising edge of wkup_pin. wkup_pin passes through two synchroniser flops and an edge detector, so the exit starts three cycles after the pin rises. ext_line has no effect in standby.
- R11: On a standby exit, core_iso drops and reg_mode returns to main. core_rst stays high for RST_CYC more cycles, and then run resumes. sbf is set at the exit and stays set until a sbf_clr pulse.
- R12: Wakeup sources have no effect in run.
- R13: During the entry sequence, a wakeup source of the requested mode aborts the entry and returns to run in the next cycle. Sources of other modes do not abort it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Low-power request strobe |
| req_mode | input | 2 | Requested mode code |
| req_lp | input | 1 | Stop-mode regulator choice (1 = low-power) |
| pll_on | input | 1 | Software pulse that re-permits the PLL |
| hse_req | input | 1 | Software level that requests the external oscillator in run |
| sbf_clr | input | 1 | Clears the sticky standby flag |
| irq_pending | input | 1 | Any enabled interrupt or event |
| ext_line | input | N_EXT | External interrupt lines |
| vdet | input | 1 | Voltage-detector output |
| rtc_alarm | input | 1 | Real-time-clock alarm |
| usb_wake | input | 1 | USB wakeup |
| wkup_pin | input | 1 | Asynchronous dedicated wakeup pin |
| ext_rst_evt | input | 1 | External reset pin event |
| wdog_rst | input | 1 | Independent watchdog reset |
| reg_ready | input | 1 | Regulator is settled in main |
| osc_ready | input | 1 | Internal oscillator is stable |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| core_clk_en | output | 1 | Core-domain clock gate enable |
| pll_en | output | 1 | PLL enable |
| hsi_en | output | 1 | Internal oscillator enable |
| hse_en | output | 1 | External oscillator enable |
| reg_mode | output | 2 | Regulator setting: 00 off, 01 main, 10 low-power |
| core_iso | output | 1 | Core-domain isolation |
| core_rst | output | 1 | Core-domain reset, active high |
| rtc_clk_en | output | 1 | Real-time-clock clock enable |
| wdg_clk_en | output | 1 | Watchdog clock enable |
| sbf | output | 1 | Sticky standby flag |

## Verification
A wrong state shows up at once as a wrong combination of gates. All outputs decode directly from the state register, so a wrong state is visible in the same cycle it is entered. Examples are the core clock running with the regulator not in main, or the regulator in low-power with an oscillator still enabled. A wrong count or a wrong wakeup qualifier shows up as a state change in the wrong cycle. The bench therefore samples each transition on the exact cycle: one cycle after a wakeup, ENTRY_CYC cycles after a request, RST_CYC cycles after a standby exit, and three cycles after a pin edge. An off-by-one in a counter, or a source wired to the wrong mode, changes an output one cycle too early or too late, or not at all.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_SLEEP = 2'b01,
    MODE_STOP  = 2'b10,
    MODE_STBY  = 2'b11
  } lp_mode_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ENTER,
    ST_SLEEP,
    ST_STOP,
    ST_STBY,
    ST_WK_REG,
    ST_WK_OSC,
    ST_STBY_RST
  } lp_state_e;

  localparam logic [1:0] REG_OFF  = 2'b00;
  localparam logic [1:0] REG_MAIN = 2'b01;
  localparam logic [1:0] REG_LP   = 2'b10;

endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  // sh[STAGES-1:0] is the synchroniser chain, sh[STAGES] holds the previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
  import lpm_pkg::*;
#(
  parameter int N_EXT = 16
) (
  input  lp_mode_e           tgt,
  input  logic               irq_pending,
  input  logic [N_EXT-1:0]   ext_line,
  input  logic               vdet,
  input  logic               rtc_alarm,
  input  logic               usb_wake,
  input  logic               pin_rise,
  input  logic               ext_rst_evt,
  input  logic               wdog_rst,
  output logic               wake
);
  logic wk_sleep, wk_stop, wk_stby;

  assign wk_sleep = irq_pending;
  assign wk_stop  = (|ext_line) | vdet | rtc_alarm | usb_wake;
  assign wk_stby  = ext_rst_evt | wdog_rst | pin_rise | rtc_alarm;

  always_comb begin
    unique case (tgt)
      MODE_SLEEP: wake = wk_sleep;
      MODE_STOP:  wake = wk_stop;
      MODE_STBY:  wake = wk_stby;
      default:    wake = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int ENTRY_CYC = 4,
  parameter int RST_CYC   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  lp_mode_e   req_mode,
  input  logic       req_lp,
  input  logic       wake,
  input  logic       reg_ready,
  input  logic       osc_ready,
  input  logic       pll_on,
  input  logic       sbf_clr,
  output lp_state_e  state,
  output lp_mode_e   tgt,
  output logic       lp_sel,
  output logic       pll_allow,
  output logic       sbf
);
  localparam int MAXC = (ENTRY_CYC > RST_CYC) ? ENTRY_CYC : RST_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  lp_state_e     nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          cnt_en, req_en;
  logic          pll_allow_nxt, sbf_nxt;

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt;
    cnt_en  = 1'b0;
    req_en  = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (req_valid && req_mode != MODE_NONE) begin
          nxt     = ST_ENTER;
          req_en  = 1'b1;
          cnt_en  = 1'b1;
          cnt_nxt = CW'(ENTRY_CYC - 1);
        end
      end
      ST_ENTER: begin
        if (wake) begin
          nxt = ST_RUN;
        end else if (cnt == '0) begin
          unique case (tgt)
            MODE_SLEEP: nxt = ST_SLEEP;
            MODE_STOP:  nxt = ST_STOP;
            default:    nxt = ST_STBY;
          endcase
        end else begin
          cnt_en  = 1'b1;
          cnt_nxt = cnt - 1'b1;
        end
      end
      ST_SLEEP:  if (wake) nxt = ST_RUN;
      ST_STOP:   if (wake) nxt = ST_WK_REG;
      ST_WK_REG: if (reg_ready) nxt = ST_WK_OSC;
      ST_WK_OSC: if (osc_ready) nxt = ST_RUN;
      ST_STBY: begin
        if (wake) begin
          nxt     = ST_STBY_RST;
          cnt_en  = 1'b1;
          cnt_nxt = CW'(RST_CYC - 1);
        end
      end
      ST_STBY_RST: begin
        if (cnt == '0) begin
          nxt = ST_RUN;
        end else begin
          cnt_en  = 1'b1;
          cnt_nxt = cnt - 1'b1;
        end
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_comb begin
    pll_allow_nxt = pll_allow;
    if (state == ST_ENTER && (nxt == ST_STOP || nxt == ST_STBY))
      pll_allow_nxt = 1'b0;
    else if (state == ST_RUN && pll_on)
      pll_allow_nxt = 1'b1;

    sbf_nxt = sbf;
    if (state == ST_STBY && nxt == ST_STBY_RST) sbf_nxt = 1'b1;
    else if (sbf_clr)                           sbf_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      cnt       <= '0;
      tgt       <= MODE_NONE;
      lp_sel    <= 1'b0;
      pll_allow <= 1'b0;
      sbf       <= 1'b0;
    end else begin
      state     <= nxt;
      pll_allow <= pll_allow_nxt;
      sbf       <= sbf_nxt;
      if (cnt_en) cnt <= cnt_nxt;
      if (req_en) begin
        tgt    <= req_mode;
        lp_sel <= req_lp;
      end
    end
  end
endmodule

// File: rtl/lpm_out_dec.sv
module lpm_out_dec
  import lpm_pkg::*;
(
  input  lp_state_e  state,
  input  logic       lp_sel,
  input  logic       pll_allow,
  input  logic       hse_req,
  output logic       cpu_clk_en,
  output logic       core_clk_en,
  output logic       pll_en,
  output logic       hsi_en,
  output logic       hse_en,
  output logic [1:0] reg_mode,
  output logic       core_iso,
  output logic       core_rst
);
  logic run_like, awake;

  assign run_like    = (state == ST_RUN) || (state == ST_ENTER);
  assign awake       = run_like || (state == ST_SLEEP);

  assign cpu_clk_en  = run_like;
  assign core_clk_en = awake || (state == ST_STBY_RST);
  assign hsi_en      = awake || (state == ST_WK_OSC) || (state == ST_STBY_RST);
  assign hse_en      = awake && hse_req;
  assign pll_en      = awake && pll_allow;
  assign core_iso    = (state == ST_STBY);
  assign core_rst    = (state == ST_STBY) || (state == ST_STBY_RST);

  always_comb begin
    unique case (state)
      ST_STOP: reg_mode = lp_sel ? REG_LP : REG_MAIN;
      ST_STBY: reg_mode = REG_OFF;
      default: reg_mode = REG_MAIN;
    endcase
  end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int N_EXT       = 16,
  parameter int ENTRY_CYC   = 4,
  parameter int RST_CYC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_mode,
  input  logic             req_lp,
  input  logic             pll_on,
  input  logic             hse_req,
  input  logic             sbf_clr,
  input  logic             irq_pending,
  input  logic [N_EXT-1:0] ext_line,
  input  logic             vdet,
  input  logic             rtc_alarm,
  input  logic             usb_wake,
  input  logic             wkup_pin,
  input  logic             ext_rst_evt,
  input  logic             wdog_rst,
  input  logic             reg_ready,
  input  logic             osc_ready,
  output logic             cpu_clk_en,
  output logic             core_clk_en,
  output logic             pll_en,
  output logic             hsi_en,
  output logic             hse_en,
  output logic [1:0]       reg_mode,
  output logic             core_iso,
  output logic             core_rst,
  output logic             rtc_clk_en,
  output logic             wdg_clk_en,
  output logic             sbf
);
  lp_state_e state;
  lp_mode_e  tgt;
  logic      lp_sel, pll_allow, pin_rise, wake;

  lpm_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(wkup_pin), .rise(pin_rise)
  );

  lpm_wake_qual #(.N_EXT(N_EXT)) u_qual (
    .tgt(tgt), .irq_pending(irq_pending), .ext_line(ext_line), .vdet(vdet),
    .rtc_alarm(rtc_alarm), .usb_wake(usb_wake), .pin_rise(pin_rise),
    .ext_rst_evt(ext_rst_evt), .wdog_rst(wdog_rst), .wake(wake)
  );

  lpm_fsm #(.ENTRY_CYC(ENTRY_CYC), .RST_CYC(RST_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_mode(lp_mode_e'(req_mode)), .req_lp(req_lp), .wake(wake),
    .reg_ready(reg_ready), .osc_ready(osc_ready), .pll_on(pll_on),
    .sbf_clr(sbf_clr), .state(state), .tgt(tgt), .lp_sel(lp_sel),
    .pll_allow(pll_allow), .sbf(sbf)
  );

  lpm_out_dec u_dec (
    .state(state), .lp_sel(lp_sel), .pll_allow(pll_allow), .hse_req(hse_req),
    .cpu_clk_en(cpu_clk_en), .core_clk_en(core_clk_en), .pll_en(pll_en),
    .hsi_en(hsi_en), .hse_en(hse_en), .reg_mode(reg_mode),
    .core_iso(core_iso), .core_rst(core_rst)
  );

  // the always-on domain keeps its clocks in every mode
  assign rtc_clk_en = 1'b1;
  assign wdg_clk_en = 1'b1;
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_clk_en,
  input logic       core_clk_en,
  input logic       pll_en,
  input logic       hsi_en,
  input logic       hse_en,
  input logic [1:0] reg_mode,
  input logic       core_iso,
  input logic       core_rst,
  input logic       sbf
);
  assert_cpu_needs_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> core_clk_en);

  assert_lp_reg_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode == 2'b10) |-> (!core_clk_en && !hsi_en && !pll_en && !hse_en));

  assert_core_clk_main_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> (reg_mode == 2'b01));

  assert_osc_after_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsi_en) |-> (reg_mode == 2'b01));

  assert_iso_reg_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_iso |-> (reg_mode == 2'b00 && !pll_en && !hsi_en && core_rst && !core_clk_en));

  assert_flag_in_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sbf) |-> (core_rst && !core_iso));
endmodule

bind lpm_seq lpm_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_clk_en(cpu_clk_en), .core_clk_en(core_clk_en),
  .pll_en(pll_en), .hsi_en(hsi_en), .hse_en(hse_en), .reg_mode(reg_mode),
  .core_iso(core_iso), .core_rst(core_rst), .sbf(sbf)
);

// File: tb/lpm_seq_tb.sv
`timescale 1ns/1ps
module lpm_seq_tb;
  localparam int ENTRY = 4;
  localparam int RSTC  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_lp, pll_on, hse_req, sbf_clr, irq_pending;
  logic [1:0] req_mode;
  logic [15:0] ext_line;
  logic vdet, rtc_alarm, usb_wake, wkup_pin, ext_rst_evt, wdog_rst, reg_ready, osc_ready;
  logic cpu_clk_en, core_clk_en, pll_en, hsi_en, hse_en, core_iso, core_rst;
  logic rtc_clk_en, wdg_clk_en, sbf;
  logic [1:0] reg_mode;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lpm_seq #(.N_EXT(16), .ENTRY_CYC(ENTRY), .RST_CYC(RSTC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_lp(req_lp), .pll_on(pll_on), .hse_req(hse_req), .sbf_clr(sbf_clr),
    .irq_pending(irq_pending), .ext_line(ext_line), .vdet(vdet),
    .rtc_alarm(rtc_alarm), .usb_wake(usb_wake), .wkup_pin(wkup_pin),
    .ext_rst_evt(ext_rst_evt), .wdog_rst(wdog_rst), .reg_ready(reg_ready),
    .osc_ready(osc_ready), .cpu_clk_en(cpu_clk_en), .core_clk_en(core_clk_en),
    .pll_en(pll_en), .hsi_en(hsi_en), .hse_en(hse_en), .reg_mode(reg_mode),
    .core_iso(core_iso), .core_rst(core_rst), .rtc_clk_en(rtc_clk_en),
    .wdg_clk_en(wdg_clk_en), .sbf(sbf)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_wakes();
    irq_pending = 0; ext_line = '0; vdet = 0; rtc_alarm = 0; usb_wake = 0;
    ext_rst_evt = 0; wdog_rst = 0;
  endtask

  // request, stay in entry ENTRY cycles, arrive in the target state
  task automatic do_enter(input logic [1:0] m, input logic lp);
    req_valid = 1; req_mode = m; req_lp = lp;
    tick(1);
    req_valid = 0; req_mode = 2'b00; req_lp = 0;
    tick(ENTRY - 1);
    chk("R3", "cpu clock during entry", cpu_clk_en, 1);
    tick(1);
  endtask

  task automatic t_reset();
    chk("R1", "cpu_clk_en", cpu_clk_en, 1);
    chk("R1", "core_clk_en", core_clk_en, 1);
    chk("R1", "hsi_en", hsi_en, 1);
    chk("R1", "pll_en", pll_en, 0);
    chk("R1", "reg_mode", reg_mode, 2'b01);
    chk("R1", "iso/rst", {core_iso, core_rst}, 0);
    chk("R1", "sbf", sbf, 0);
    chk("R2", "aon clocks", {rtc_clk_en, wdg_clk_en}, 2'b11);
  endtask

  task automatic t_run_ignores();
    ext_line = 16'h0100; vdet = 1; rtc_alarm = 1; usb_wake = 1; irq_pending = 1;
    ext_rst_evt = 1; wdog_rst = 1; wkup_pin = 1;
    tick(4);
    chk("R12", "outputs in run", {cpu_clk_en, core_clk_en, core_rst, core_iso, reg_mode}, 6'b110001);
    chk("R12", "sbf in run", sbf, 0);
    clear_wakes(); wkup_pin = 0;
    req_valid = 1; req_mode = 2'b00; tick(1); req_valid = 0;
    tick(ENTRY + 1);
    chk("R3", "mode 00 ignored", cpu_clk_en, 1);
  endtask

  task automatic t_sleep();
    pll_on = 1; tick(1); pll_on = 0;
    chk("R8", "pll permitted by pulse", pll_en, 1);
    hse_req = 1;
    do_enter(2'b01, 0);
    chk("R4", "cpu gated", cpu_clk_en, 0);
    chk("R4", "core/hsi/hse/pll kept", {core_clk_en, hsi_en, hse_en, pll_en}, 4'hF);
    chk("R4", "reg main", reg_mode, 2'b01);
    ext_line = 16'hFFFF; rtc_alarm = 1; tick(2); clear_wakes();
    chk("R4", "stop sources ignored in sleep", cpu_clk_en, 0);
    req_valid = 1; req_mode = 2'b11; tick(1); req_valid = 0; req_mode = 0;
    irq_pending = 1; tick(1); irq_pending = 0;
    chk("R4", "irq wake", cpu_clk_en, 1);
    tick(ENTRY + 2);
    chk("R3", "request outside run ignored", {cpu_clk_en, core_rst}, 2'b10);
    hse_req = 0;
  endtask

  task automatic t_stop_lp();
    hse_req = 1;
    do_enter(2'b10, 1);
    chk("R5", "clocks gated", {cpu_clk_en, core_clk_en}, 0);
    chk("R5", "osc/pll off", {pll_en, hsi_en, hse_en}, 0);
    chk("R5", "reg low-power", reg_mode, 2'b10);
    irq_pending = 1; wkup_pin = 1; tick(5); clear_wakes(); wkup_pin = 0;
    chk("R6", "irq/pin ignored in stop", reg_mode, 2'b10);
    ext_line = 16'h0080; tick(1); clear_wakes();
    chk("R6", "ext line wakes", reg_mode, 2'b01);
    chk("R7", "osc still off", {hsi_en, core_clk_en}, 0);
    tick(3);
    chk("R7", "waits for reg_ready", {hsi_en, core_clk_en}, 0);
    reg_ready = 1; tick(1);
    chk("R7", "osc on, clocks gated", {hsi_en, core_clk_en, cpu_clk_en}, 3'b100);
    tick(2);
    chk("R7", "waits for osc_ready", core_clk_en, 0);
    osc_ready = 1; tick(1); reg_ready = 0; osc_ready = 0;
    chk("R7", "clocks back", {cpu_clk_en, core_clk_en}, 2'b11);
    chk("R8", "pll held off", pll_en, 0);
    chk("R5", "hse follows request again", hse_en, 1);
    pll_on = 1; tick(1); pll_on = 0;
    chk("R8", "pll re-enabled", pll_en, 1);
    hse_req = 0;
  endtask

  task automatic t_stop_main();
    do_enter(2'b10, 0);
    chk("R5", "reg main in stop", reg_mode, 2'b01);
    usb_wake = 1; tick(1); clear_wakes();
    chk("R6", "usb wake leaves stop", {reg_mode, hsi_en}, 3'b010);
    reg_ready = 1; osc_ready = 1; tick(2); reg_ready = 0; osc_ready = 0;
    chk("R7", "run after handshakes", cpu_clk_en, 1);
    do_enter(2'b10, 0);
    vdet = 1; tick(1); clear_wakes();
    chk("R6", "vdet wakes", {core_clk_en, reg_mode}, 3'b001);
    reg_ready = 1; osc_ready = 1; tick(2); reg_ready = 0; osc_ready = 0;
  endtask

  task automatic t_abort();
    req_valid = 1; req_mode = 2'b10; tick(1); req_valid = 0; req_mode = 0;
    rtc_alarm = 1; tick(1); clear_wakes();
    tick(ENTRY + 1);
    chk("R13", "entry aborted", {cpu_clk_en, core_clk_en}, 2'b11);
    req_valid = 1; req_mode = 2'b10; tick(1); req_valid = 0; req_mode = 0;
    irq_pending = 1; tick(1); irq_pending = 0;
    tick(ENTRY - 1);
    chk("R13", "foreign source does not abort", core_clk_en, 0);
    rtc_alarm = 1; tick(1); clear_wakes();
    reg_ready = 1; osc_ready = 1; tick(2); reg_ready = 0; osc_ready = 0;
    chk("R13", "back in run", cpu_clk_en, 1);
  endtask

  task automatic t_stby_rtc();
    do_enter(2'b11, 0);
    chk("R9", "reg off", reg_mode, 2'b00);
    chk("R9", "iso/rst", {core_iso, core_rst}, 2'b11);
    chk("R9", "gates", {cpu_clk_en, core_clk_en, pll_en, hsi_en}, 0);
    chk("R2", "aon clocks in standby", {rtc_clk_en, wdg_clk_en}, 2'b11);
    ext_line = 16'hFFFF; usb_wake = 1; tick(3); clear_wakes();
    chk("R10", "ext lines ignored", core_iso, 1);
    rtc_alarm = 1; tick(1); clear_wakes();
    chk("R11", "iso drop, reg main", {core_iso, reg_mode}, 3'b001);
    chk("R11", "sbf set", sbf, 1);
    tick(RSTC - 1);
    chk("R11", "reset still held", {core_rst, cpu_clk_en}, 2'b10);
    tick(1);
    chk("R11", "reset released", {core_rst, cpu_clk_en}, 2'b01);
    tick(3);
    chk("R11", "sbf sticky", sbf, 1);
    sbf_clr = 1; tick(1); sbf_clr = 0;
    chk("R11", "sbf cleared", sbf, 0);
  endtask

  task automatic t_stby_pin();
    do_enter(2'b11, 0);
    wkup_pin = 1; tick(2);
    chk("R10", "pin not yet through sync", core_iso, 1);
    tick(1);
    chk("R10", "pin edge exits", core_iso, 0);
    tick(RSTC);
    chk("R10", "run after pin exit", {core_rst, cpu_clk_en}, 2'b01);
    do_enter(2'b11, 0);
    tick(4);
    chk("R10", "held-high pin no new edge", core_iso, 1);
    wdog_rst = 1; tick(1); wdog_rst = 0; wkup_pin = 0;
    chk("R10", "watchdog exits", core_iso, 0);
    tick(RSTC);
    do_enter(2'b11, 0);
    ext_rst_evt = 1; tick(1); clear_wakes();
    chk("R10", "reset pin exits", core_iso, 0);
    tick(RSTC);
    chk("R10", "run again", cpu_clk_en, 1);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_mode = 0; req_lp = 0; pll_on = 0; hse_req = 0;
    sbf_clr = 0; wkup_pin = 0; reg_ready = 0; osc_ready = 0;
    clear_wakes();
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_run_ignores();
    t_sleep();
    t_stop_lp();
    t_stop_main();
    t_abort();
    t_stby_rtc();
    t_stby_pin();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule